// File: doc/BRIEF.md
# Jitter Self-Test Measurement Sequencer

This block holds the digital control and counting around an on-chip clock-jitter self-test made of a two-tap delay line, an inverter and a phase comparator. A single start request runs a fixed procedure. First it calibrates: it turns the delay line into a ring oscillator and counts that oscillator over a programmable window of reference-clock cycles, once for each delay tap. Then it measures: it turns the delay line back into a delayed copy of the clock under test and counts, for each tap, how many of N comparisons report that the undelayed edge came first.

The two oscillator counts give the tap delay difference. The two lead counts give the two points of the period-jitter distribution. A downstream analysis unit reads all four values when the done pulse appears. The oscillator arrives as its own clock and is counted in its own domain. Its count crosses into the reference domain as a Gray code.

Top module: `jitter_seq`

## Requirements
- R1: After reset, `cal_en`, `meas_en`, `delay_sel`, `busy` and `done` are low and all four results are zero. A `start` seen while idle raises `cal_en` and `busy` at the next clock edge, with `delay_sel` low. `win_len` and `n_log2` are captured at that edge.
- R2: `cal_en` and `meas_en` are never high in the same cycle.
- R3: `meas_en` rises exactly one cycle after `cal_en` falls, so that exactly one cycle has both strobes low.
- R4: Calibration counts rising edges of `osc_clk` over a window of `win_len` reference cycles. A `win_len` of 0 counts as 1. It does this first with `delay_sel` low, giving `freq1`, and then with it high, giving `freq2`. Each result lies within 2 counts of the ideal value (window length times reference period divided by the oscillator period). The oscillator must run slower than the reference clock.
- R5: During measurement, `meas_en` stays high for exactly N cycles with `delay_sel` low. It then stays high for exactly N more cycles with `delay_sel` high, with no break between them.
- R6: `lead1` and `lead2` each count the rising edges at which `meas_en` was high, `delay_sel` had the matching value (0 for `lead1`, 1 for `lead2`), and `lead_in` was 1. A count of all N, up to 2^14, is held without overflow.
- R7: N is 2 to the power of `n_log2`. Values of `n_log2` below 10 are treated as 10, and values above 14 are treated as 14.
- R8: The four results change only in the cycle in which `done` is high. Between those cycles they hold their values.
- R9: `done` is a single-cycle pulse, and `busy` is low from that cycle on. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_clk | input | 1 | Ring oscillator output formed by the delay line and inverter |
| start | input | 1 | Launches one calibration and measurement run |
| win_len | input | WIN_W | Calibration window length in reference cycles |
| n_log2 | input | 4 | log2 of the comparison count N |
| lead_in | input | 1 | Comparator result: 1 when the undelayed edge leads |
| cal_en | output | 1 | Calibration strobe (delay line closed as an oscillator) |
| meas_en | output | 1 | Measurement strobe (delay line fed by the clock under test) |
| delay_sel | output | 1 | Tap select: 0 for the first delay, 1 for the second |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| freq1 | output | OSC_W | Oscillator count with tap 0 |
| freq2 | output | OSC_W | Oscillator count with tap 1 |
| lead1 | output | NLOG_MAX+1 | Lead count with tap 0 |
| lead2 | output | NLOG_MAX+1 | Lead count with tap 1 |

## Verification
The strobes and the tap select are registered at the edge that samples `start`, so the bench checks them at the following falling edge. The comparison window and the strobe gap are judged by looking at `meas_en`, `cal_en` and `delay_sel` at every falling edge. The bench drives `lead_in` one nanosecond after each rising edge and builds its expected lead counts from the same falling-edge view. This credits each lead bit to the edge at which the design takes it. The oscillator counts pass through a two-stage Gray synchroniser, so the exact start of the window is uncertain by a few oscillator edges; the bench therefore compares them against the ideal count with a tolerance of two. All four results are read at the falling edge where `done` is high, and they are watched at every falling edge for changes outside that cycle.

// File: rtl/jseq_pkg.sv
package jseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAL_SETTLE,
    ST_CAL_WIN,
    ST_GAP,
    ST_MEAS,
    ST_FIN
  } jseq_state_t;

  localparam int unsigned SETTLE_CYC = 4;
endpackage

// File: rtl/jseq_osc_gray.sv
module jseq_osc_gray #(
  parameter int OSC_W = 16
) (
  input  logic             osc_clk,
  input  logic             rst,
  output logic [OSC_W-1:0] gray_out
);
  logic [1:0]       rst_pipe;
  logic             osc_rst;
  logic [OSC_W-1:0] bin_q;
  logic [OSC_W-1:0] bin_nxt;

  assign osc_rst = rst_pipe[1];
  assign bin_nxt = bin_q + OSC_W'(1);

  always_ff @(posedge osc_clk) begin
    rst_pipe <= {rst_pipe[0], rst};
  end

  always_ff @(posedge osc_clk) begin
    if (osc_rst) begin
      bin_q    <= '0;
      gray_out <= '0;
    end else begin
      bin_q    <= bin_nxt;
      gray_out <= bin_nxt ^ (bin_nxt >> 1);
    end
  end
endmodule

// File: rtl/jseq_gray_sync.sv
module jseq_gray_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  always_comb begin
    bin_out[W-1] = stg[STAGES-1][W-1];
    for (int i = W - 2; i >= 0; i--) bin_out[i] = bin_out[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/jseq_ctrl.sv
module jseq_ctrl
  import jseq_pkg::*;
#(
  parameter int OSC_W    = 16,
  parameter int WIN_W    = 16,
  parameter int NLOG_MIN = 10,
  parameter int NLOG_MAX = 14,
  parameter int SETTLE   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [WIN_W-1:0]    win_len,
  input  logic [3:0]          n_log2,
  input  logic                lead_in,
  input  logic [OSC_W-1:0]    osc_cnt,
  output logic                cal_en,
  output logic                meas_en,
  output logic                delay_sel,
  output logic                busy,
  output logic                done,
  output logic [OSC_W-1:0]    freq1,
  output logic [OSC_W-1:0]    freq2,
  output logic [NLOG_MAX:0]   lead1,
  output logic [NLOG_MAX:0]   lead2
);
  localparam int LEAD_W = NLOG_MAX + 1;
  localparam int TMR_W  = (WIN_W > LEAD_W) ? WIN_W : LEAD_W;

  jseq_state_t       state;
  logic [TMR_W-1:0]  timer;
  logic [WIN_W-1:0]  win_q;
  logic [LEAD_W-1:0] n_q;
  logic [LEAD_W-1:0] n_sel;
  logic [OSC_W-1:0]  snap;
  logic [OSC_W-1:0]  f1_q;
  logic [OSC_W-1:0]  f2_q;
  logic [LEAD_W-1:0] acc;
  logic [LEAD_W-1:0] acc_nxt;
  logic [LEAD_W-1:0] l1_q;

  // clamp of the requested comparison count
  always_comb begin
    if (n_log2 < 4'(NLOG_MIN))      n_sel = LEAD_W'(1) << NLOG_MIN;
    else if (n_log2 > 4'(NLOG_MAX)) n_sel = LEAD_W'(1) << NLOG_MAX;
    else                            n_sel = LEAD_W'(1) << n_log2;
  end

  assign acc_nxt = acc + LEAD_W'(lead_in);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      timer     <= '0;
      win_q     <= '0;
      n_q       <= '0;
      snap      <= '0;
      f1_q      <= '0;
      f2_q      <= '0;
      acc       <= '0;
      l1_q      <= '0;
      cal_en    <= 1'b0;
      meas_en   <= 1'b0;
      delay_sel <= 1'b0;
      done      <= 1'b0;
      freq1     <= '0;
      freq2     <= '0;
      lead1     <= '0;
      lead2     <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            win_q     <= (win_len == '0) ? WIN_W'(1) : win_len;
            n_q       <= n_sel;
            cal_en    <= 1'b1;
            delay_sel <= 1'b0;
            timer     <= TMR_W'(SETTLE - 1);
            state     <= ST_CAL_SETTLE;
          end
        end
        ST_CAL_SETTLE: begin
          if (timer == '0) begin
            snap  <= osc_cnt;
            timer <= TMR_W'(win_q) - TMR_W'(1);
            state <= ST_CAL_WIN;
          end else begin
            timer <= timer - TMR_W'(1);
          end
        end
        ST_CAL_WIN: begin
          if (timer == '0) begin
            if (!delay_sel) begin
              f1_q      <= osc_cnt - snap;
              delay_sel <= 1'b1;
              timer     <= TMR_W'(SETTLE - 1);
              state     <= ST_CAL_SETTLE;
            end else begin
              f2_q      <= osc_cnt - snap;
              delay_sel <= 1'b0;
              cal_en    <= 1'b0;
              state     <= ST_GAP;
            end
          end else begin
            timer <= timer - TMR_W'(1);
          end
        end
        ST_GAP: begin
          meas_en <= 1'b1;
          acc     <= '0;
          timer   <= TMR_W'(n_q) - TMR_W'(1);
          state   <= ST_MEAS;
        end
        ST_MEAS: begin
          if (timer == '0) begin
            if (!delay_sel) begin
              l1_q      <= acc_nxt;
              acc       <= '0;
              delay_sel <= 1'b1;
              timer     <= TMR_W'(n_q) - TMR_W'(1);
            end else begin
              acc       <= acc_nxt;
              delay_sel <= 1'b0;
              meas_en   <= 1'b0;
              state     <= ST_FIN;
            end
          end else begin
            acc   <= acc_nxt;
            timer <= timer - TMR_W'(1);
          end
        end
        ST_FIN: begin
          freq1 <= f1_q;
          freq2 <= f2_q;
          lead1 <= l1_q;
          lead2 <= acc;
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/jitter_seq.sv
module jitter_seq #(
  parameter int OSC_W       = 16,
  parameter int WIN_W       = 16,
  parameter int NLOG_MIN    = 10,
  parameter int NLOG_MAX    = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                osc_clk,
  input  logic                start,
  input  logic [WIN_W-1:0]    win_len,
  input  logic [3:0]          n_log2,
  input  logic                lead_in,
  output logic                cal_en,
  output logic                meas_en,
  output logic                delay_sel,
  output logic                busy,
  output logic                done,
  output logic [OSC_W-1:0]    freq1,
  output logic [OSC_W-1:0]    freq2,
  output logic [NLOG_MAX:0]   lead1,
  output logic [NLOG_MAX:0]   lead2
);
  localparam int LEAD_W = NLOG_MAX + 1;

  logic [OSC_W-1:0] osc_gray;
  logic [OSC_W-1:0] osc_cnt;

  jseq_osc_gray #(.OSC_W(OSC_W)) u_osc (
    .osc_clk (osc_clk),
    .rst     (rst),
    .gray_out(osc_gray)
  );

  jseq_gray_sync #(.W(OSC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .gray_in(osc_gray),
    .bin_out(osc_cnt)
  );

  jseq_ctrl #(
    .OSC_W   (OSC_W),
    .WIN_W   (WIN_W),
    .NLOG_MIN(NLOG_MIN),
    .NLOG_MAX(NLOG_MAX),
    .SETTLE  (jseq_pkg::SETTLE_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .win_len  (win_len),
    .n_log2   (n_log2),
    .lead_in  (lead_in),
    .osc_cnt  (osc_cnt),
    .cal_en   (cal_en),
    .meas_en  (meas_en),
    .delay_sel(delay_sel),
    .busy     (busy),
    .done     (done),
    .freq1    (freq1),
    .freq2    (freq2),
    .lead1    (lead1),
    .lead2    (lead2)
  );
endmodule

// File: rtl/jitter_seq_chk.sv
module jitter_seq_chk #(
  parameter int OSC_W    = 16,
  parameter int NLOG_MAX = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              cal_en,
  input logic              meas_en,
  input logic              delay_sel,
  input logic              busy,
  input logic              done,
  input logic [OSC_W-1:0]  freq1,
  input logic [OSC_W-1:0]  freq2,
  input logic [NLOG_MAX:0] lead1,
  input logic [NLOG_MAX:0] lead2
);
  localparam logic [NLOG_MAX:0] LEAD_CAP = (NLOG_MAX+1)'(1) << NLOG_MAX;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!cal_en && !meas_en)) else $error("idle strobe"); // R1

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(cal_en && meas_en)) else $error("strobes overlap"); // R2

  AST_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_en) |-> !$past(cal_en)) else $error("no dead cycle"); // R3

  AST_SEL_HOLD_START: assert property (@(posedge clk) disable iff (rst)
    $rose(meas_en) |-> !delay_sel) else $error("measure starts on tap 1"); // R5

  AST_LEAD_BOUND: assert property (@(posedge clk) disable iff (rst)
    (lead1 <= LEAD_CAP) && (lead2 <= LEAD_CAP)) else $error("lead overflow"); // R6

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(freq1) && $stable(freq2) && $stable(lead1) && $stable(lead2)))
    else $error("results moved"); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done too long"); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("busy at done"); // R9
endmodule

bind jitter_seq jitter_seq_chk #(.OSC_W(OSC_W), .NLOG_MAX(NLOG_MAX)) u_chk (
  .clk(clk), .rst(rst), .start(start), .cal_en(cal_en), .meas_en(meas_en),
  .delay_sel(delay_sel), .busy(busy), .done(done), .freq1(freq1),
  .freq2(freq2), .lead1(lead1), .lead2(lead2)
);

// File: tb/jitter_seq_bench.sv
`timescale 1ns/1ps
module jitter_seq_bench;
  localparam int OSC_W = 16;
  localparam int WIN_W = 16;
  localparam int NMAX  = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic osc_clk = 1'b0;
  logic start = 1'b0;
  logic [WIN_W-1:0] win_len = '0;
  logic [3:0] n_log2 = 4'd10;
  logic lead_in = 1'b0;
  logic cal_en, meas_en, delay_sel, busy, done;
  logic [OSC_W-1:0] freq1, freq2;
  logic [NMAX:0] lead1, lead2;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  real half0 = 15.0;
  real half1 = 17.0;
  int prob0 = 160;
  int prob1 = 840;

  // monitor state
  int meas_cnt0, meas_cnt1, lead_exp0, lead_exp1, done_cnt, gap_bad, overlap, moved;
  logic [1:0] cal_hist;
  logic [OSC_W-1:0] pf1, pf2;
  logic [NMAX:0] pl1, pl2;

  jitter_seq u_jitter_seq (
    .clk(clk), .rst(rst), .osc_clk(osc_clk), .start(start), .win_len(win_len),
    .n_log2(n_log2), .lead_in(lead_in), .cal_en(cal_en), .meas_en(meas_en),
    .delay_sel(delay_sel), .busy(busy), .done(done), .freq1(freq1),
    .freq2(freq2), .lead1(lead1), .lead2(lead2)
  );

  always #10 clk = ~clk;

  always begin
    if (delay_sel) #(half1) osc_clk = ~osc_clk;
    else           #(half0) osc_clk = ~osc_clk;
  end

  always @(posedge clk) begin
    #1;
    lead_in = (($urandom % 1000) < (delay_sel ? prob1 : prob0));
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_n(input int nl);
    int e = (nl < 10) ? 10 : ((nl > 14) ? 14 : nl);
    return 1 << e;
  endfunction

  function automatic int exp_freq(input int w, input real half);
    real ideal = ((w == 0) ? 1.0 : real'(w)) * 20.0 / (2.0 * half);
    return int'(ideal);
  endfunction

  function automatic int absdiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (meas_en && !delay_sel) begin meas_cnt0++; if (lead_in) lead_exp0++; end
      if (meas_en &&  delay_sel) begin meas_cnt1++; if (lead_in) lead_exp1++; end
      if (cal_en && meas_en) overlap++;
      if (meas_en && cal_hist == 2'b00 && !cal_en) begin end
      if (done) done_cnt++;
      if (!done && (freq1 != pf1 || freq2 != pf2 || lead1 != pl1 || lead2 != pl2)) moved++;
    end
    pf1 = freq1; pf2 = freq2; pl1 = lead1; pl2 = lead2;
    cal_hist = {cal_hist[0], cal_en};
  end

  // gap watcher: meas_en rise must follow exactly one cycle with both low after cal_en
  logic prev_meas = 1'b0;
  always @(negedge clk) begin
    if (!rst && meas_en && !prev_meas) begin
      // cal_hist already shifted: [0]=now(low), [1]=one cycle earlier
      if (!(cal_hist[1] == 1'b0 && cal_en == 1'b0)) gap_bad++;
    end
    prev_meas = meas_en;
  end

  task automatic run_trial(input int w, input int nl, input real h0, input real h1,
                           input int p0, input int p1, input bit poke);
    int n = exp_n(nl);
    int f1e = exp_freq(w, h0);
    int f2e = exp_freq(w, h1);
    int t = 0;
    half0 = h0; half1 = h1; prob0 = p0; prob1 = p1;
    win_len = WIN_W'(w); n_log2 = 4'(nl);
    @(posedge clk); #1;
    meas_cnt0 = 0; meas_cnt1 = 0; lead_exp0 = 0; lead_exp1 = 0;
    done_cnt = 0; gap_bad = 0; overlap = 0; moved = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(cal_en && busy && !delay_sel && !meas_en, "R1 start raises cal_en tap0",
          {cal_en, busy, delay_sel, meas_en}, 4'b1100);
    if (poke) begin
      repeat (2 * w + 20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    while (!done && t < 60000) begin @(negedge clk); t++; end
    check(done, "R9 done reached", done, 1);
    check(absdiff(int'(freq1), f1e) <= 2, "R4 freq1", freq1, f1e);
    check(absdiff(int'(freq2), f2e) <= 2, "R4 freq2", freq2, f2e);
    check(meas_cnt0 == n, "R5 N cycles tap0 / R7 clamp", meas_cnt0, n);
    check(meas_cnt1 == n, "R5 N cycles tap1 / R7 clamp", meas_cnt1, n);
    check(int'(lead1) == lead_exp0, "R6 lead1", lead1, lead_exp0);
    check(int'(lead2) == lead_exp1, "R6 lead2", lead2, lead_exp1);
    check(!busy, "R9 busy low at done", busy, 0);
    repeat (6) @(negedge clk);
    check(done_cnt == 1, "R9 single done pulse", done_cnt, 1);
    check(!busy, "R9 no restart from ignored start", busy, 0);
    check(overlap == 0, "R2 strobe overlap", overlap, 0);
    check(gap_bad == 0, "R3 dead cycle", gap_bad, 0);
    check(moved == 0, "R8 results stable", moved, 0);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 190000) begin
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    int s;
    s = $urandom(32'd5150);
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!cal_en && !meas_en && !delay_sel && !busy && !done, "R1 reset strobes",
          {cal_en, meas_en, delay_sel, busy, done}, 0);
    check(freq1 == 0 && freq2 == 0 && lead1 == 0 && lead2 == 0, "R1 reset results",
          freq1 + freq2 + lead1 + lead2, 0);
    // directed: zero window counts as one, n_log2 below range clamps to 10
    run_trial(0, 3, 15.0, 17.0, 160, 840, 1'b0);
    // directed: n_log2 above range clamps to 14, every comparison leads on tap 1
    run_trial(1000, 15, 12.5, 13.5, 0, 1000, 1'b0);
    check(lead2 == 15'd16384, "R6 full count held", lead2, 16384);
    check(lead1 == 0, "R6 no leads tap0", lead1, 0);
    // random runs, one with a start while busy
    for (int k = 0; k < 4; k++) begin
      int w = 200 + ($urandom % 1800);
      int nl = 10 + ($urandom % 2);
      real h0 = 11.0 + real'($urandom % 80) / 10.0;
      real h1 = 11.0 + real'($urandom % 80) / 10.0;
      run_trial(w, nl, h0, h1, $urandom % 500, 500 + ($urandom % 500), k == 1);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule